// File: doc/BRIEF.md
# Interrupt entry sequencer for an in-order core

This block sits beside the fetch stage of a simple in-order processor. It decides whether a pending normal interrupt request is taken and, if so, carries out the entry actions. The request line is level sensitive. The block looks at it only when the core signals an instruction boundary, meaning the point just before the next instruction is fetched. The request is gated by the interrupt-disable bit of the status register.

On entry, the block does five things in one clock edge:
- it switches the processor mode to the interrupt mode;
- it sets the disable bit;
- it copies the old mode and disable bit into a saved-status register;
- it writes the address of the next instruction into the link register of the interrupt mode;
- it redirects fetch to a fixed vector address.

Each processor mode has its own banked link register, so the interrupted task's link register is never touched. A return strobe restores mode and disable bit from the saved status and redirects fetch to the interrupt-mode link register. Because the line is level sensitive, a request still held high after the return is taken again at the very next boundary, before the resumed task runs an instruction.

Software changes the status register through a write port. This is how a handler re-enables interrupts or how the kernel leaves supervisor mode. Software writes the link register of the current mode through a second write port.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only in a cycle where `boundary_i` is 1. `irq_taken_o` is 1 in the cycle after a take and 0 otherwise.
- R2: A request is taken only when `irq_i` is 1, `irq_dis_o` is 0 and `ret_i` is 0. While the disable bit is set, a held request has no effect on mode, fetch or the link registers.
- R3: One cycle after a take, `mode_o` equals the interrupt mode. Mode codes are 0 user, 1 interrupt, 2 supervisor, 3 system.
- R4: One cycle after a take, `irq_dis_o` is 1.
- R5: One cycle after a take, `fetch_pc_o` equals the parameter `VECTOR` (default 0x18) and `fetch_redirect_o` is 1 for that single cycle.
- R6: A request held high across a return that clears the disable bit is taken again at the next boundary.
- R7: On a take, the interrupt-mode link register (`irq_lr_o`) loads `next_pc_i`, and the link registers of the other modes keep their values. `lr_rd_o` shows the link register of the mode currently on `mode_o`. `lr_wr_i` writes the current mode's link register except in a take cycle.
- R8: On a take, `saved_mode_o`/`saved_dis_o` load the mode and disable bit that were current before the take.
- R9: `ret_i` loads mode and disable bit from the saved status and loads `fetch_pc_o` from the old `irq_lr_o`, with `fetch_redirect_o` 1.
- R10: After reset: mode supervisor (2), disable bit 1, saved status supervisor with disable 1, `fetch_pc_o` = `RESET_PC` (0), redirect 0, taken 0, all link registers 0.
- R11: Priority within one cycle is return, then take, then status write. A status write (`sr_wr_i`) loads `sr_mode_i`/`sr_dis_i` only when neither of the other two happens.
- R12: A boundary without a take or return loads `fetch_pc_o` from `next_pc_i` with `fetch_redirect_o` 0. With no boundary, `fetch_pc_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Level-sensitive normal interrupt request |
| boundary_i | input | 1 | Instruction boundary: next fetch is about to start |
| next_pc_i | input | AW | Address of the next instruction |
| ret_i | input | 1 | Return-from-interrupt strobe |
| sr_wr_i | input | 1 | Status register write strobe |
| sr_mode_i | input | 2 | Mode value to write |
| sr_dis_i | input | 1 | Disable bit value to write |
| lr_wr_i | input | 1 | Write strobe for current mode's link register |
| lr_wdata_i | input | AW | Link register write data |
| fetch_pc_o | output | AW | Next fetch address |
| fetch_redirect_o | output | 1 | Fetch address is a redirect (entry or return) |
| irq_taken_o | output | 1 | An interrupt was taken on the last edge |
| mode_o | output | 2 | Current processor mode |
| irq_dis_o | output | 1 | Interrupt-disable bit |
| saved_mode_o | output | 2 | Saved mode |
| saved_dis_o | output | 1 | Saved disable bit |
| lr_rd_o | output | AW | Link register of the current mode |
| irq_lr_o | output | AW | Link register of the interrupt mode |

## Verification
Every piece of state is visible at the ports one cycle after the edge that changes it. A wrong disable bit shows at the next boundary as a missing or spurious `irq_taken_o` together with a vector redirect. A mis-banked link register write shows on `lr_rd_o` as soon as the mode returns to the bank that was hit. A corrupted saved status surfaces one cycle after the next `ret_i`, as the wrong mode, and possibly a lost re-take of a held request.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   localparam int MODE_W = 2;
   localparam int NUM_MODES = 2 ** MODE_W;

   typedef enum logic [MODE_W-1:0] {
      MODE_USER = 2'd0,
      MODE_IRQ  = 2'd1,
      MODE_SUPV = 2'd2,
      MODE_SYS  = 2'd3
   } mode_e;

   typedef struct packed {
      mode_e mode;
      logic  dis;
   } status_t;

   localparam status_t STATUS_RESET = '{mode: MODE_SUPV, dis: 1'b1};
   localparam status_t STATUS_ENTRY = '{mode: MODE_IRQ,  dis: 1'b1};

endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate (
   input  logic boundary_i,
   input  logic irq_i,
   input  logic dis_i,
   input  logic ret_i,
   output logic take_o
);
   // Request is sampled only between instructions and only when unmasked;
   // a return in the same cycle has precedence.
   always_comb begin
      take_o = boundary_i & irq_i & ~dis_i & ~ret_i;
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import irq_entry_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    take_i,
   input  logic    ret_i,
   input  logic    wr_i,
   input  status_t wdata_i,
   output status_t cur_o,
   output status_t saved_o
);
   status_t cur_q, saved_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_q   <= STATUS_RESET;
         saved_q <= STATUS_RESET;
      end else if (ret_i) begin
         cur_q   <= saved_q;
      end else if (take_i) begin
         saved_q <= cur_q;
         cur_q   <= STATUS_ENTRY;
      end else if (wr_i) begin
         cur_q   <= wdata_i;
      end
   end

   assign cur_o   = cur_q;
   assign saved_o = saved_q;
endmodule

// File: rtl/irq_lr_bank.sv
module irq_lr_bank
   import irq_entry_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          take_i,
   input  logic [AW-1:0] entry_pc_i,
   input  logic          wr_i,
   input  logic [AW-1:0] wdata_i,
   input  mode_e         cur_mode_i,
   output logic [AW-1:0] rd_data_o,
   output logic [AW-1:0] irq_lr_o
);
   logic [AW-1:0] lr_q [NUM_MODES];

   for (genvar g = 0; g < NUM_MODES; g++) begin : g_bank
      localparam bit IS_IRQ_BANK = (g == int'(MODE_IRQ));
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            lr_q[g] <= '0;
         end else if (IS_IRQ_BANK && take_i) begin
            lr_q[g] <= entry_pc_i;
         end else if (wr_i && !take_i && (int'(cur_mode_i) == g)) begin
            lr_q[g] <= wdata_i;
         end
      end
   end

   assign rd_data_o = lr_q[cur_mode_i];
   assign irq_lr_o  = lr_q[MODE_IRQ];
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int          AW       = 32,
   parameter logic [63:0] VECTOR   = 64'h18,
   parameter logic [63:0] RESET_PC = 64'h0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          irq_i,
   input  logic          boundary_i,
   input  logic [AW-1:0] next_pc_i,
   input  logic          ret_i,
   input  logic          sr_wr_i,
   input  logic [1:0]    sr_mode_i,
   input  logic          sr_dis_i,
   input  logic          lr_wr_i,
   input  logic [AW-1:0] lr_wdata_i,
   output logic [AW-1:0] fetch_pc_o,
   output logic          fetch_redirect_o,
   output logic          irq_taken_o,
   output logic [1:0]    mode_o,
   output logic          irq_dis_o,
   output logic [1:0]    saved_mode_o,
   output logic          saved_dis_o,
   output logic [AW-1:0] lr_rd_o,
   output logic [AW-1:0] irq_lr_o
);
   localparam logic [AW-1:0] VEC_ADDR  = VECTOR[AW-1:0];
   localparam logic [AW-1:0] RST_ADDR  = RESET_PC[AW-1:0];

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("irq_entry_seq: AW must lie in 8..64");
   end
   if (VECTOR[1:0] != 2'b00) begin : g_bad_vec
      $error("irq_entry_seq: VECTOR must be word aligned");
   end

   logic    take;
   status_t cur_st, saved_st, wr_st;
   logic [AW-1:0] fetch_q;
   logic          redirect_q, taken_q;

   assign wr_st = '{mode: mode_e'(sr_mode_i), dis: sr_dis_i};

   irq_take_gate u_gate (
      .boundary_i (boundary_i),
      .irq_i      (irq_i),
      .dis_i      (cur_st.dis),
      .ret_i      (ret_i),
      .take_o     (take)
   );

   irq_status_reg u_status (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (take),
      .ret_i   (ret_i),
      .wr_i    (sr_wr_i),
      .wdata_i (wr_st),
      .cur_o   (cur_st),
      .saved_o (saved_st)
   );

   irq_lr_bank #(.AW(AW)) u_lr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (take),
      .entry_pc_i (next_pc_i),
      .wr_i       (lr_wr_i),
      .wdata_i    (lr_wdata_i),
      .cur_mode_i (cur_st.mode),
      .rd_data_o  (lr_rd_o),
      .irq_lr_o   (irq_lr_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fetch_q    <= RST_ADDR;
         redirect_q <= 1'b0;
         taken_q    <= 1'b0;
      end else begin
         taken_q <= take;
         if (ret_i) begin
            fetch_q    <= irq_lr_o;
            redirect_q <= 1'b1;
         end else if (take) begin
            fetch_q    <= VEC_ADDR;
            redirect_q <= 1'b1;
         end else begin
            redirect_q <= 1'b0;
            if (boundary_i) fetch_q <= next_pc_i;
         end
      end
   end

   assign fetch_pc_o       = fetch_q;
   assign fetch_redirect_o = redirect_q;
   assign irq_taken_o      = taken_q;
   assign mode_o           = cur_st.mode;
   assign irq_dis_o        = cur_st.dis;
   assign saved_mode_o     = saved_st.mode;
   assign saved_dis_o      = saved_st.dis;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int          AW     = 32,
   parameter logic [63:0] VECTOR = 64'h18
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          irq_i,
   input logic          boundary_i,
   input logic [AW-1:0] next_pc_i,
   input logic          ret_i,
   input logic          sr_wr_i,
   input logic [1:0]    sr_mode_i,
   input logic          sr_dis_i,
   input logic [AW-1:0] fetch_pc_o,
   input logic          fetch_redirect_o,
   input logic          irq_taken_o,
   input logic [1:0]    mode_o,
   input logic          irq_dis_o,
   input logic [1:0]    saved_mode_o,
   input logic          saved_dis_o,
   input logic [AW-1:0] irq_lr_o
);
   logic req_ok;
   assign req_ok = boundary_i && irq_i && !irq_dis_o && !ret_i;

   assert_no_midinstr_take_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !boundary_i |=> !irq_taken_o);
   assert_masked_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_i && irq_dis_o) |=> !irq_taken_o);
   assert_entry_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ok |=> (mode_o == 2'd1) && irq_taken_o);
   assert_entry_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ok |=> irq_dis_o);
   assert_entry_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ok |=> (fetch_pc_o == VECTOR[AW-1:0]) && fetch_redirect_o);
   assert_entry_link_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ok |=> irq_lr_o == $past(next_pc_i));
   assert_saved_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ok |=> (saved_mode_o == $past(mode_o)) && !saved_dis_o);
   assert_return_restore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i |=> (mode_o == $past(saved_mode_o)) && (irq_dis_o == $past(saved_dis_o))
                && (fetch_pc_o == $past(irq_lr_o)) && fetch_redirect_o);
   assert_status_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sr_wr_i && !req_ok && !ret_i) |=> (mode_o == $past(sr_mode_i)) && (irq_dis_o == $past(sr_dis_i)));
   assert_plain_boundary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_i && !req_ok && !ret_i) |=> (fetch_pc_o == $past(next_pc_i)) && !fetch_redirect_o);
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .VECTOR(VECTOR)) chk_i (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .irq_i            (irq_i),
   .boundary_i       (boundary_i),
   .next_pc_i        (next_pc_i),
   .ret_i            (ret_i),
   .sr_wr_i          (sr_wr_i),
   .sr_mode_i        (sr_mode_i),
   .sr_dis_i         (sr_dis_i),
   .fetch_pc_o       (fetch_pc_o),
   .fetch_redirect_o (fetch_redirect_o),
   .irq_taken_o      (irq_taken_o),
   .mode_o           (mode_o),
   .irq_dis_o        (irq_dis_o),
   .saved_mode_o     (saved_mode_o),
   .saved_dis_o      (saved_dis_o),
   .irq_lr_o         (irq_lr_o)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
   localparam int AW = 16;
   localparam logic [AW-1:0] VEC = 16'h0018;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 0, bnd = 0, ret = 0, srw = 0, srd = 0, lw = 0;
   logic [1:0] srm = '0;
   logic [AW-1:0] npc = '0, lwd = '0;

   logic [AW-1:0] fetch_pc, lr_rd, irq_lr;
   logic redir, taken, dis, sdis;
   logic [1:0] mode, smode;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   logic [1:0] m_mode = 2, m_smode = 2;
   logic m_dis = 1, m_sdis = 1, m_redir = 0, m_taken = 0;
   logic [AW-1:0] m_fpc = '0;
   logic [AW-1:0] m_lr [4] = '{default: '0};

   always #2.5 clk = ~clk;

   irq_entry_seq #(.AW(AW), .VECTOR(64'h18), .RESET_PC(64'h0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .boundary_i(bnd), .next_pc_i(npc),
      .ret_i(ret), .sr_wr_i(srw), .sr_mode_i(srm), .sr_dis_i(srd),
      .lr_wr_i(lw), .lr_wdata_i(lwd), .fetch_pc_o(fetch_pc), .fetch_redirect_o(redir),
      .irq_taken_o(taken), .mode_o(mode), .irq_dis_o(dis), .saved_mode_o(smode),
      .saved_dis_o(sdis), .lr_rd_o(lr_rd), .irq_lr_o(irq_lr));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R5 R9 R12 fetch_pc"}, 64'(fetch_pc), 64'(m_fpc));
      chk({ctx, " R5 R12 redirect"}, 64'(redir), 64'(m_redir));
      chk({ctx, " R1 R2 taken"}, 64'(taken), 64'(m_taken));
      chk({ctx, " R3 R9 R11 mode"}, 64'(mode), 64'(m_mode));
      chk({ctx, " R4 R6 dis"}, 64'(dis), 64'(m_dis));
      chk({ctx, " R8 saved_mode"}, 64'(smode), 64'(m_smode));
      chk({ctx, " R8 saved_dis"}, 64'(sdis), 64'(m_sdis));
      chk({ctx, " R7 lr_rd"}, 64'(lr_rd), 64'(m_lr[m_mode]));
      chk({ctx, " R7 irq_lr"}, 64'(irq_lr), 64'(m_lr[1]));
   endtask

   task automatic step(input string ctx, input logic i_irq, input logic i_bnd, input logic i_ret,
                       input logic i_srw, input logic [1:0] i_srm, input logic i_srd,
                       input logic i_lw, input logic [AW-1:0] i_lwd, input logic [AW-1:0] i_npc);
      logic tk;
      logic [AW-1:0] old_irq_lr;
      irq = i_irq; bnd = i_bnd; ret = i_ret; srw = i_srw; srm = i_srm; srd = i_srd;
      lw = i_lw; lwd = i_lwd; npc = i_npc;
      tk = i_bnd && i_irq && !m_dis && !i_ret;
      old_irq_lr = m_lr[1];
      if (i_lw && !tk) m_lr[m_mode] = i_lwd;
      if (i_ret) begin
         m_fpc = old_irq_lr; m_redir = 1; m_mode = m_smode; m_dis = m_sdis;
      end else if (tk) begin
         m_smode = m_mode; m_sdis = m_dis; m_mode = 2'd1; m_dis = 1;
         m_lr[1] = i_npc; m_fpc = VEC; m_redir = 1;
      end else begin
         if (i_srw) begin m_mode = i_srm; m_dis = i_srd; end
         m_redir = 0;
         if (i_bnd) m_fpc = i_npc;
      end
      m_taken = tk;
      @(posedge clk);
      @(negedge clk);
      check_all(ctx);
      irq = 0; bnd = 0; ret = 0; srw = 0; lw = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("R10 reset");
      rst_n = 1;
      @(negedge clk);
      check_all("R10 after release");

      // near-exhaustive sweep over starting status and control inputs
      for (int m = 0; m < 4; m++)
         for (int d = 0; d < 2; d++)
            for (int k = 0; k < 16; k++) begin
               int idx;
               idx = m * 32 + d * 16 + k;
               step("R11 setup", 0, 0, 0, 1, 2'(m), 1'(d), 0, '0, '0);
               step("R1 R2 R9 R11 sweep", k[0], k[1], k[2], k[3], 2'(~m), 1'(~d),
                    1'(idx % 2), AW'(16'h100 + idx * 3), AW'(16'h200 + idx * 4));
            end

      // held request across return: taken again at first boundary
      step("R11 to user", 0, 0, 0, 1, 2'd0, 1'b0, 0, '0, '0);
      step("R7 user lr", 0, 0, 0, 0, 2'd0, 1'b0, 1, 16'h4444, '0);
      step("R6 first take", 1, 1, 0, 0, 2'd0, 1'b0, 0, '0, 16'h1230);
      step("R2 masked hold", 1, 1, 0, 0, 2'd0, 1'b0, 0, '0, 16'h0020);
      step("R1 no boundary", 1, 0, 0, 0, 2'd0, 1'b0, 0, '0, 16'h0024);
      step("R9 return", 1, 0, 1, 0, 2'd0, 1'b0, 0, '0, '0);
      chk("R7 user lr kept after return", 64'(lr_rd), 64'h4444);
      step("R6 retake", 1, 1, 0, 0, 2'd0, 1'b0, 0, '0, 16'h1230);
      chk("R6 retake taken", 64'(taken), 64'd1);
      chk("R5 retake vector", 64'(fetch_pc), 64'(VEC));
      step("R11 clear dis in irq", 0, 0, 0, 1, 2'd1, 1'b0, 0, '0, '0);
      step("R12 plain boundary", 0, 1, 0, 0, 2'd0, 1'b0, 0, '0, 16'h0abc);
      step("R12 hold", 0, 0, 0, 0, 2'd0, 1'b0, 0, '0, 16'h0def);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule